// File: doc/BRIEF.md
# Consumer IR Transmit Carrier Modulator

This block turns a serial bit-string into the drive signal for an infrared LED. A new bit is taken from `tx_bit` on each `baud_tick`, which comes from the baud divisor the same way a UART's bit rate does. There are no start, stop or parity bits. A 1 bit leaves the LED dark for the whole bit time. A 0 bit keys a carrier whose period and high time are set by two programmable counts.

The carrier counter is clocked either on every clock cycle or once every `PRE_DIV` cycles, chosen by a speed-select input. A two-bit mode input selects how a run of 0 bits is keyed:
- In continuous mode the carrier runs for every 0 bit in the run.
- In the six-pulse and eight-pulse modes a burst of that many carrier pulses is armed only when a 0 bit follows a 1 bit. A run that ends early cuts the burst short.

Top module: `irtx_carrier_mod`

## Requirements
- R1: While `rst_n` is low, `led_on` is 0, and it stays 0 after reset until the first 0 bit is taken. The bit register resets to 1.
- R2: While the current bit is 1, `led_on` is 0 for the whole bit time.
- R3: With mode 2'b00 (continuous), `led_on` carries the carrier for the full length of every run of 0 bits, across bit boundaries. Over a run of A cycles with effective period Pe and high time We, there are ceil(A/Pe) pulses and floor(A/Pe)*We + min(A mod Pe, We) high cycles.
- R4: With mode 2'b01, a 0 bit that follows a 1 bit produces exactly six carrier pulses when the run lasts at least six carrier periods.
- R5: With mode 2'b10, a 0 bit that follows a 1 bit produces exactly eight carrier pulses when the run lasts at least eight carrier periods.
- R6: In the burst modes, further 0 bits in the same run do not re-arm the burst. Only a 1-to-0 transition starts a new burst.
- R7: If a run of 0 bits ends before the burst is complete, the burst is truncated. Fewer pulses are sent and the LED goes dark with the following 1 bit.
- R8: The carrier phase restarts at each 1-to-0 transition, so the first pulse of every run is a full-width pulse of We cycles (or the whole run if that is shorter).
- R9: With `hs_sel` = 1 the carrier counter steps every clock (Pe = period, We = width). With `hs_sel` = 0 it steps every `PRE_DIV` clocks (Pe = period*PRE_DIV, We = width*PRE_DIV).
- R10: Mode 2'b11 behaves as continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe that loads the next bit |
| tx_bit | input | 1 | Serial bit to send, taken on `baud_tick` |
| carrier_period | input | CNT_W | Carrier period in carrier steps (2 or more) |
| carrier_width | input | CNT_W | Carrier high time in steps (1 to period-1) |
| hs_sel | input | 1 | 1: step each clock; 0: step every PRE_DIV clocks |
| mode | input | 2 | 00/11 continuous, 01 six-pulse burst, 10 eight-pulse burst |
| led_on | output | 1 | Active-high LED drive |

## Verification
The bench sends bit patterns that mix isolated 0 bits, long 0 runs and short 0 runs. It counts LED rising edges and high cycles and compares them with values computed run by run from the period, width, speed select, bit length and mode:
- Long runs separate continuous keying from a burst that stops at six or eight pulses.
- Short runs expose truncation.
- Two runs split by a single 1 bit show that each burst is armed anew.
- One long run shows that later 0 bits do not re-arm.

The width of the first pulse checks the phase restart and the prescaled carrier step. Randomised settings cover all four modes and both speed selects.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [1:0] {
    KEY_CONT     = 2'b00,
    KEY_SIX      = 2'b01,
    KEY_EIGHT    = 2'b10,
    KEY_CONT_ALT = 2'b11
  } key_mode_e;

  localparam int unsigned BURST_W = 4;

  function automatic logic [BURST_W-1:0] burst_len(input logic [1:0] m);
    case (m)
      KEY_SIX:   burst_len = BURST_W'(6);
      KEY_EIGHT: burst_len = BURST_W'(8);
      default:   burst_len = '0;
    endcase
  endfunction

  function automatic logic is_burst(input logic [1:0] m);
    is_burst = (m == KEY_SIX) || (m == KEY_EIGHT);
  endfunction
endpackage

// File: rtl/irtx_carrier_gen.sv
module irtx_carrier_gen #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hs_sel,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic             wrap
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step  = hs_sel || (pre_q == PRE_LAST);
    pre_d = pre_q;
    if (restart || step) pre_d = '0;
    else                 pre_d = pre_q + PRE_W'(1);
  end

  always_comb begin
    wrap  = step && !restart && (cnt_q >= period - CNT_W'(1));
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  assign pulse = (cnt_q < width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  a_r8_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  a_r9_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
    (PRE_DIV > 1 && !hs_sel && step) |=> (hs_sel || !step));
endmodule

// File: rtl/irtx_burst_ctl.sv
module irtx_burst_ctl
  import irtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [1:0] mode,
  input  logic       wrap,
  output logic       burst_open
);
  logic [BURST_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (arm)                          left_d = burst_len(mode);
    else if (wrap && left_q != '0)    left_d = left_q - BURST_W'(1);
  end

  assign burst_open = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  a_r5_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= BURST_W'(8));

  a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && left_q == '0) |=> (left_q == '0));
endmodule

// File: rtl/irtx_carrier_mod.sv
module irtx_carrier_mod
  import irtx_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_tick,
  input  logic             tx_bit,
  input  logic [CNT_W-1:0] carrier_period,
  input  logic [CNT_W-1:0] carrier_width,
  input  logic             hs_sel,
  input  logic [1:0]       mode,
  output logic             led_on
);
  logic bit_q, bit_d;
  logic led_d;
  logic arm;
  logic pulse, wrap, burst_open;

  assign arm = baud_tick && !tx_bit && bit_q;

  always_comb begin
    bit_d = bit_q;
    if (baud_tick) bit_d = tx_bit;
  end

  irtx_carrier_gen #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (arm),
    .hs_sel  (hs_sel),
    .period  (carrier_period),
    .width   (carrier_width),
    .pulse   (pulse),
    .wrap    (wrap)
  );

  irtx_burst_ctl u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .mode       (mode),
    .wrap       (wrap),
    .burst_open (burst_open)
  );

  always_comb begin
    led_d = !bit_q && pulse && (!is_burst(mode) || burst_open);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= 1'b1;
      led_on <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      led_on <= led_d;
    end
  end

  a_r2_one_dark: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q |=> !led_on);

  a_r7_cut_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && tx_bit) ##1 1'b1 |=> !led_on);
endmodule

// File: tb/tb_irtx_carrier_mod.sv
module tb_irtx_carrier_mod;
  localparam int CNT_W = 8;
  localparam int PRE_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic tx_bit = 1'b1;
  logic [CNT_W-1:0] carrier_period = 8'd4;
  logic [CNT_W-1:0] carrier_width = 8'd2;
  logic hs_sel = 1'b1;
  logic [1:0] mode = 2'b00;
  logic led_on;

  int total = 0;
  int bad = 0;
  int n_pulse = 0, n_high = 0, first_w = 0;
  logic first_done = 1'b0;
  logic led_prev = 1'b0;
  logic measuring = 1'b0;

  irtx_carrier_mod #(.CNT_W(CNT_W), .PRE_DIV(PRE_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_bit(tx_bit),
    .carrier_period(carrier_period), .carrier_width(carrier_width),
    .hs_sel(hs_sel), .mode(mode), .led_on(led_on)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (measuring) begin
      if (led_on && !led_prev) n_pulse++;
      if (led_on) n_high++;
      if (led_on && !first_done) first_w++;
      if (!led_on && first_w > 0) first_done = 1'b1;
    end
    led_prev = led_on;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_stats(input logic [31:0] pat, input int n,
      input logic [1:0] md, input int p, input int w, input logic hs, input int l,
      output int pulses, output int high, output int fw);
    int s, pe, we, k, a, lim, nb;
    logic prev;
    s = hs ? 1 : PRE_DIV;
    pe = p * s; we = w * s;
    nb = (md == 2'b01) ? 6 : (md == 2'b10) ? 8 : 0;
    pulses = 0; high = 0; fw = 0; k = 0; prev = 1'b1;
    for (int i = 0; i <= n; i++) begin
      logic b;
      b = (i < n) ? pat[i] : 1'b1;
      if (!b) k++;
      else if (k > 0) begin
        a = k * l;
        lim = (nb > 0 && nb * pe < a) ? nb * pe : a;
        if (fw == 0) fw = (we < a) ? we : a;
        pulses += (lim + pe - 1) / pe;
        high += (lim / pe) * we + (((lim % pe) < we) ? (lim % pe) : we);
        k = 0;
      end
      prev = b;
    end
  endfunction

  task automatic run_pat(input logic [31:0] pat, input int n, input int l,
      output int pulses, output int high, output int fw);
    @(negedge clk);
    n_pulse = 0; n_high = 0; first_w = 0; first_done = 1'b0;
    measuring = 1'b1;
    for (int i = 0; i < n + 2; i++) begin
      tx_bit = (i < n) ? pat[i] : 1'b1;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      repeat (l - 1) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    measuring = 1'b0;
    pulses = n_pulse; high = n_high; fw = first_w;
  endtask

  task automatic trial(input string req, input logic [31:0] pat, input int n,
      input logic [1:0] md, input int p, input int w, input logic hs, input int l,
      input logic chk_fw);
    int ap, ah, af, ep, eh, ef;
    mode = md; carrier_period = CNT_W'(p); carrier_width = CNT_W'(w); hs_sel = hs;
    expect_stats(pat, n, md, p, w, hs, l, ep, eh, ef);
    run_pat(pat, n, l, ap, ah, af);
    check({req, " pulses"}, ap, ep);
    check({req, " high"}, ah, eh);
    if (chk_fw) check({req, " first width"}, af, ef);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 led in reset", int'(led_on), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 led after reset", int'(led_on), 0);

    // R2: all ones keeps dark
    trial("R2 all ones", 32'hFFFF, 8, 2'b00, 4, 2, 1'b1, 10, 1'b0);
    // R3: continuous over a long run
    trial("R3 continuous run", 32'b1_0000_1, 6, 2'b00, 5, 2, 1'b1, 12, 1'b1);
    // R4: six pulses on a long run
    trial("R4 six burst", 32'b1_000000_1, 8, 2'b01, 4, 1, 1'b1, 10, 1'b1);
    // R5: eight pulses
    trial("R5 eight burst", 32'b1_000000_1, 8, 2'b10, 4, 2, 1'b1, 10, 1'b1);
    // R6: one long run gives one burst, two runs give two
    trial("R6 long run", 32'b1_0000000000_1, 12, 2'b01, 3, 1, 1'b1, 8, 1'b0);
    trial("R6 two runs", 32'b1_00_1_00_1, 7, 2'b10, 3, 1, 1'b1, 20, 1'b0);
    // R7: truncated burst
    trial("R7 truncated", 32'b1_0_1, 3, 2'b10, 6, 3, 1'b1, 14, 1'b0);
    // R8 + R9: slow carrier step, first pulse width
    trial("R9 slow step", 32'b1_000_1, 5, 2'b00, 5, 3, 1'b0, 40, 1'b1);
    trial("R8 short first", 32'b1_0_1, 3, 2'b00, 10, 8, 1'b1, 5, 1'b1);
    // R10: mode 3 behaves as continuous
    trial("R10 mode 3", 32'b1_00000_1, 7, 2'b11, 4, 1, 1'b1, 10, 1'b0);

    for (int it = 0; it < 24; it++) begin
      logic [31:0] pat;
      int p, w, l;
      p = 2 + int'($urandom % 11);
      w = 1 + int'($urandom % (p - 1));
      l = 2 + int'($urandom % 40);
      pat = $urandom;
      pat[0] = 1'b1;
      trial("R3 R4 R5 R7 R9 random", pat, 14, 2'($urandom % 4), p, w,
            1'($urandom % 2), l, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule